// File: doc/BRIEF.md
# Auto-Stepping Test Readback Register

This block is a byte-wide test register that a host reads and writes over a simple strobe port. It holds a 3-bit mode and four analog-select bits. The byte returned on a read depends on the current mode. It can be a palette colour component, a fixed identification byte, a ones-accumulation checksum of one colour channel, or an analog-test status byte that carries the result of an external comparator. The palette values, the accumulator values and the comparator result all arrive as inputs.

Each read also advances the mode along a fixed successor table. The table has three separate loops. The palette components form a three-step cycle, the accumulators form another three-step cycle, and the analog test holds its own mode. The identification mode falls back to the start of the palette cycle. A write loads the mode and the select bits directly and does not step.

The mode is an enumerated state: `M_PAL_R` (0), `M_PAL_G` (1), `M_PAL_B` (2), `M_ID` (3), `M_ACC_R` (4), `M_ACC_G` (5), `M_ACC_B` (6) and `M_ANALOG` (7). A read causes these transitions: `M_PAL_R`→`M_PAL_G`→`M_PAL_B`→`M_PAL_R`, `M_ID`→`M_PAL_R`, `M_ACC_R`→`M_ACC_G`→`M_ACC_B`→`M_ACC_R`, and `M_ANALOG`→`M_ANALOG`. A write moves the mode from any state to any state. With no strobe, the mode holds.

Top module: `test_readback_reg`

## Requirements
- R1: In modes 0, 1 and 2, `rd_data` equals `pal_r`, `pal_g` and `pal_b` respectively. A read steps the mode 0→1→2→0.
- R2: In mode 3, `rd_data` is the constant 0x75. A read moves the mode to 0.
- R3: In modes 4, 5 and 6, `rd_data` equals `acc_r`, `acc_g` and `acc_b` respectively. A read steps the mode 4→5→6→4.
- R4: In mode 7, `rd_data` is {select[3:0], comparator bit, 3'b111}, and a read leaves the mode at 7.
- R5: The select bits come from write data bits 7:4. Select bit 0 (write bit 4) chooses the reference, bit 1 chooses blue, bit 2 chooses green and bit 3 chooses red. `ana_sel` carries the select bits only in mode 7 and is 0 in every other mode.
- R6: In mode 7, `rd_data` bit 3 follows `cmp_in` in the same cycle.
- R7: A write loads the mode from `wr_data[2:0]` and the select bits from `wr_data[7:4]` without stepping. When a write and a read happen in the same cycle, the write wins.
- R8: The mode steps exactly once for each clock cycle in which `rd_en` is high and `wr_en` is low. It holds when neither strobe is high.
- R9: Reset sets the mode to 0 and clears all select bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write byte: mode in bits 2:0, select bits in 7:4 |
| rd_en | input | 1 | Read strobe; the mode steps at the end of the cycle |
| rd_data | output | 8 | Byte for the current mode, valid during the read cycle |
| pal_r | input | 8 | Palette red component |
| pal_g | input | 8 | Palette green component |
| pal_b | input | 8 | Palette blue component |
| acc_r | input | 8 | Red ones-accumulation value |
| acc_g | input | 8 | Green ones-accumulation value |
| acc_b | input | 8 | Blue ones-accumulation value |
| cmp_in | input | 1 | External comparator result |
| ana_sel | output | 4 | Gated analog select: {red, green, blue, reference} |

## Verification
The six data inputs each hold a distinct byte, so `rd_data` alone shows which mode the register is in after every strobe. A vector table walks each loop of the successor table all the way round. Returning to the first value proves that a loop closes and does not spill into the next mode. Writes carry select patterns that are not symmetric, such as 1010, 0101 and 0001, so the bench can tell a swapped or shifted select bit from a correct one. It also checks that the select bits are masked outside mode 7. Directed cases cover the following:
- a read and a write in the same cycle;
- a read held for two cycles, which must give two steps;
- toggling the comparator;
- reset in the middle of a run.

// File: rtl/trr_pkg.sv
package trr_pkg;

    localparam int DATA_W = 8;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 4;
    localparam logic [DATA_W-1:0] ID_BYTE = 8'h75;

    typedef enum logic [MODE_W-1:0] {
        M_PAL_R  = 3'd0,
        M_PAL_G  = 3'd1,
        M_PAL_B  = 3'd2,
        M_ID     = 3'd3,
        M_ACC_R  = 3'd4,
        M_ACC_G  = 3'd5,
        M_ACC_B  = 3'd6,
        M_ANALOG = 3'd7
    } test_mode_e;

endpackage

// File: rtl/trr_sequencer.sv
module trr_sequencer
    import trr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [MODE_W-1:0]    wr_mode,
    input  logic [SEL_W-1:0]     wr_sel,
    output test_mode_e           mode,
    output logic [SEL_W-1:0]     sel
);

    test_mode_e       mode_q, mode_d, succ;
    logic [SEL_W-1:0] sel_q, sel_d;

    // successor of a read: three separate loops
    always_comb begin
        unique case (mode_q)
            M_PAL_R:  succ = M_PAL_G;
            M_PAL_G:  succ = M_PAL_B;
            M_PAL_B:  succ = M_PAL_R;
            M_ID:     succ = M_PAL_R;
            M_ACC_R:  succ = M_ACC_G;
            M_ACC_G:  succ = M_ACC_B;
            M_ACC_B:  succ = M_ACC_R;
            M_ANALOG: succ = M_ANALOG;
            default:  succ = M_PAL_R;
        endcase
    end

    always_comb begin
        mode_d = mode_q;
        sel_d  = sel_q;
        if (wr_en) begin
            mode_d = test_mode_e'(wr_mode);
            sel_d  = wr_sel;
        end else if (rd_en) begin
            mode_d = succ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_PAL_R;
            sel_q  <= '0;
        end else begin
            mode_q <= mode_d;
            sel_q  <= sel_d;
        end
    end

    assign mode = mode_q;
    assign sel  = sel_q;

    AST_PAL_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && mode_q == M_PAL_B) |=> mode_q == M_PAL_R); // R1
    AST_ID_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && mode_q == M_ID) |=> mode_q == M_PAL_R); // R2
    AST_ACC_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && mode_q == M_ACC_B) |=> mode_q == M_ACC_R); // R3
    AST_ANALOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && mode_q == M_ANALOG) |=> mode_q == M_ANALOG); // R4
    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_q == $past(wr_mode) && sel_q == $past(wr_sel))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> ($stable(mode_q) && $stable(sel_q))); // R8

endmodule

// File: rtl/trr_readmux.sv
module trr_readmux
    import trr_pkg::*;
(
    input  test_mode_e           mode,
    input  logic [SEL_W-1:0]     sel,
    input  logic [DATA_W-1:0]    pal_r,
    input  logic [DATA_W-1:0]    pal_g,
    input  logic [DATA_W-1:0]    pal_b,
    input  logic [DATA_W-1:0]    acc_r,
    input  logic [DATA_W-1:0]    acc_g,
    input  logic [DATA_W-1:0]    acc_b,
    input  logic                 cmp_in,
    output logic [DATA_W-1:0]    rd_data,
    output logic [SEL_W-1:0]     ana_sel
);

    always_comb begin
        ana_sel = '0;
        unique case (mode)
            M_PAL_R:  rd_data = pal_r;
            M_PAL_G:  rd_data = pal_g;
            M_PAL_B:  rd_data = pal_b;
            M_ID:     rd_data = ID_BYTE;
            M_ACC_R:  rd_data = acc_r;
            M_ACC_G:  rd_data = acc_g;
            M_ACC_B:  rd_data = acc_b;
            M_ANALOG: begin
                rd_data = {sel, cmp_in, 3'b111};
                ana_sel = sel;
            end
            default:  rd_data = '0;
        endcase
    end

    always_comb begin
        AST_SEL_GATED: assert (mode == M_ANALOG || ana_sel == '0); // R5
        AST_ID_VALUE: assert (mode != M_ID || rd_data == 8'h75); // R2
        AST_CMP_BIT: assert (mode != M_ANALOG || rd_data[3] == cmp_in); // R6
    end

endmodule

// File: rtl/test_readback_reg.sv
module test_readback_reg
    import trr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    input  logic [7:0]  pal_r,
    input  logic [7:0]  pal_g,
    input  logic [7:0]  pal_b,
    input  logic [7:0]  acc_r,
    input  logic [7:0]  acc_g,
    input  logic [7:0]  acc_b,
    input  logic        cmp_in,
    output logic [3:0]  ana_sel
);

    test_mode_e       mode;
    logic [SEL_W-1:0] sel;

    trr_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_mode (wr_data[MODE_W-1:0]),
        .wr_sel  (wr_data[DATA_W-1:DATA_W-SEL_W]),
        .mode    (mode),
        .sel     (sel)
    );

    trr_readmux u_mux (
        .mode    (mode),
        .sel     (sel),
        .pal_r   (pal_r),
        .pal_g   (pal_g),
        .pal_b   (pal_b),
        .acc_r   (acc_r),
        .acc_g   (acc_g),
        .acc_b   (acc_b),
        .cmp_in  (cmp_in),
        .rd_data (rd_data),
        .ana_sel (ana_sel)
    );

endmodule

// File: tb/test_test_readback_reg.sv
`timescale 1ns/1ps
module test_test_readback_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [3:0] ana_sel;
    logic       cmp_in = 1'b1;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    test_readback_reg i_test_readback_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .pal_r(8'hA1), .pal_g(8'hA2), .pal_b(8'hA3),
        .acc_r(8'hB4), .acc_g(8'hB5), .acc_b(8'hB6),
        .cmp_in(cmp_in), .ana_sel(ana_sel)
    );

    // vector: {op[1:0] (0 idle, 1 write, 2 read), wdata, expected rd_data after, expected ana_sel}
    localparam int NV = 15;
    localparam logic [21:0] VEC [NV] = '{
        {2'd1, 8'h00, 8'hA1, 4'h0},   // R7 load mode 0
        {2'd2, 8'h00, 8'hA2, 4'h0},   // R1 0->1
        {2'd2, 8'h00, 8'hA3, 4'h0},   // R1 1->2
        {2'd2, 8'h00, 8'hA1, 4'h0},   // R1 2->0
        {2'd1, 8'h03, 8'h75, 4'h0},   // R2 id byte
        {2'd2, 8'h00, 8'hA1, 4'h0},   // R2 3->0
        {2'd1, 8'h04, 8'hB4, 4'h0},   // R3
        {2'd2, 8'h00, 8'hB5, 4'h0},   // R3 4->5
        {2'd2, 8'h00, 8'hB6, 4'h0},   // R3 5->6
        {2'd2, 8'h00, 8'hB4, 4'h0},   // R3 6->4
        {2'd1, 8'hA7, 8'hAF, 4'hA},   // R4 R5 analog, sel 1010
        {2'd2, 8'h00, 8'hAF, 4'hA},   // R4 stays 7
        {2'd0, 8'h00, 8'hAF, 4'hA},   // R8 idle holds
        {2'd1, 8'h52, 8'hA3, 4'h0},   // R5 sel masked outside mode 7
        {2'd0, 8'h00, 8'hA3, 4'h0}    // R8 idle holds
    };

    task automatic check(input string req, input logic [7:0] exp_d, input logic [3:0] exp_s);
        total++;
        if (rd_data !== exp_d || ana_sel !== exp_s) begin
            bad++;
            $display("FAIL %s: rd_data=%h ana_sel=%h expected rd_data=%h ana_sel=%h",
                     req, rd_data, ana_sel, exp_d, exp_s);
        end
    endtask

    task automatic apply(input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        wr_en = w; rd_en = r; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R9 reset", 8'hA1, 4'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][21:20] == 2'd1, VEC[i][21:20] == 2'd2, VEC[i][19:12]);
            check($sformatf("vector %0d", i), VEC[i][11:4], VEC[i][3:0]);
        end

        // R6: comparator bit follows cmp_in in mode 7
        apply(1'b1, 1'b0, 8'h17);
        check("R5 ref-only select", 8'h1F, 4'h1);
        cmp_in = 1'b0; #1;
        check("R6 cmp low", 8'h17, 4'h1);
        cmp_in = 1'b1; #1;
        check("R6 cmp high", 8'h1F, 4'h1);

        // R7: write wins over simultaneous read
        apply(1'b1, 1'b1, 8'h01);
        check("R7 write beats read", 8'hA2, 4'h0);

        // R8: read held two cycles steps twice
        apply(1'b1, 1'b0, 8'h04);
        @(negedge clk);
        rd_en = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rd_en = 1'b0;
        check("R8 two steps", 8'hB6, 4'h0);

        // R9: reset mid-run clears mode and select bits
        apply(1'b1, 1'b0, 8'hF7);
        check("R5 all selects", 8'hFF, 4'hF);
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R9 mode cleared", 8'hA1, 4'h0);
        @(negedge clk); rst_n = 1'b1;
        apply(1'b0, 1'b1, 8'h00);
        check("R9 read after reset", 8'hA2, 4'h0);
        apply(1'b1, 1'b0, 8'h07);
        check("R9 select after write", 8'h0F, 4'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule